// File: doc/BRIEF.md
# GF(8) Symbol Multiplier

This block multiplies two 3-bit symbols of the finite field GF(8), built on the primitive polynomial x^3 + x + 1. It is the single multiply primitive that a small Reed-Solomon encoder and decoder share. The block does not use a 64-entry product table. Each nonzero operand is turned into its exponent of the primitive element alpha by a 7-entry logarithm map. The two exponents are added modulo 7. A 7-entry antilogarithm map then turns the sum back into a symbol. A zero operand has no logarithm, so it forces the product to zero.

The parameter `REG_OUT` sets the timing. When it is 1, which is the default, the product goes through one output register that clears on reset. When it is 0, the product is purely combinational and `clk` and `rst_n` have no effect.

Top module: `gf8_mul`

## Requirements
- R1: For any two operands, `prod_o` equals the carry-less product of `a_i` and `b_i` reduced modulo x^3 + x + 1. Symbol bit k is the coefficient of x^k.
- R2: When either operand is 3'd0, the product is 3'd0.
- R3: When one operand is 3'd1 (alpha^0), the product equals the other operand.
- R4: Swapping `a_i` and `b_i` leaves the product unchanged.
- R5: With `REG_OUT`=1, the product of the inputs present at a rising clock edge appears on `prod_o` after that edge. It holds until the next edge, even if the inputs change between edges.
- R6: While `rst_n` is low, a registered `prod_o` is 3'd0, whatever the inputs are.
- R7: When both operands are nonzero, the product is nonzero.
- R8: Exponent sums of 7 or more wrap around. alpha^i times alpha^j gives alpha^((i+j) mod 7), for example 5*7=6, 7*7=3 and 5*5=7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| a_i | input | 3 | First field symbol |
| b_i | input | 3 | Second field symbol |
| prod_o | output | 3 | Field product |

## Verification
The assertions assume that every 3-bit input pattern is a valid field symbol. They also assume that the inputs are known (not X) at each sampling edge, because the checker tracks the operands behind the output register for exactly one cycle. The stimulus changes operands only on falling clock edges and drives defined values at all times, reset included. It walks all 64 operand pairs, so no pattern lies outside what the checker expects.

// File: rtl/gf8_mul.sv
module gf8_mul #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] a_i,
  input  logic [2:0] b_i,
  output logic [2:0] prod_o
);

  localparam int SW    = 3;
  localparam int ORDER = (1 << SW) - 1;

  function automatic logic [SW-1:0] sym_log(input logic [SW-1:0] s);
    case (s)
      3'd1:    sym_log = 3'd0;
      3'd2:    sym_log = 3'd1;
      3'd4:    sym_log = 3'd2;
      3'd3:    sym_log = 3'd3;
      3'd6:    sym_log = 3'd4;
      3'd7:    sym_log = 3'd5;
      3'd5:    sym_log = 3'd6;
      default: sym_log = 3'd0;
    endcase
  endfunction

  function automatic logic [SW-1:0] sym_alog(input logic [SW-1:0] e);
    case (e)
      3'd0:    sym_alog = 3'd1;
      3'd1:    sym_alog = 3'd2;
      3'd2:    sym_alog = 3'd4;
      3'd3:    sym_alog = 3'd3;
      3'd4:    sym_alog = 3'd6;
      3'd5:    sym_alog = 3'd7;
      3'd6:    sym_alog = 3'd5;
      default: sym_alog = 3'd1;
    endcase
  endfunction

  logic [SW-1:0] log_a, log_b, exp_sum, prod_c;
  logic [SW:0]   raw_sum;
  logic          has_zero;

  assign log_a    = sym_log(a_i);
  assign log_b    = sym_log(b_i);
  assign raw_sum  = {1'b0, log_a} + {1'b0, log_b};
  assign exp_sum  = (raw_sum >= (SW+1)'(ORDER)) ? SW'(raw_sum - (SW+1)'(ORDER)) : raw_sum[SW-1:0];
  assign has_zero = (a_i == '0) || (b_i == '0);
  assign prod_c   = has_zero ? '0 : sym_alog(exp_sum);

  generate
    if (REG_OUT) begin : g_reg
      logic [SW-1:0] prod_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prod_q <= '0;
        else        prod_q <= prod_c;
      end
      assign prod_o = prod_q;
    end else begin : g_comb
      assign prod_o = prod_c;
    end
  endgenerate

endmodule

// File: rtl/gf8_mul_chk.sv
module gf8_mul_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] a_i,
  input logic [2:0] b_i,
  input logic [2:0] prod_o
);

  logic [2:0] op_a, op_b;

  generate
    if (REG_OUT) begin : g_lag
      logic [2:0] a_q, b_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          a_q <= '0;
          b_q <= '0;
        end else begin
          a_q <= a_i;
          b_q <= b_i;
        end
      end
      assign op_a = a_q;
      assign op_b = b_q;
    end else begin : g_now
      assign op_a = a_i;
      assign op_b = b_i;
    end
  endgenerate

  AST_ZERO_ABSORB: assert property (@(posedge clk) disable iff (!rst_n)
    (op_a == 3'd0 || op_b == 3'd0) |-> (prod_o == 3'd0)); // R2

  AST_ONE_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_a == 3'd1) |-> (prod_o == op_b)); // R3

  AST_NONZERO_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (op_a != 3'd0 && op_b != 3'd0) |-> (prod_o != 3'd0)); // R7

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(op_a) && $stable(op_b)) |-> $stable(prod_o)); // R5

endmodule

bind gf8_mul gf8_mul_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i), .prod_o(prod_o)
);

// File: tb/gf8_mul_bench.sv
`timescale 1ns/1ps
module gf8_mul_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] a = 3'd7, b = 3'd7;
  logic [2:0] prod;
  int nvec = 0;
  int nerr = 0;

  always #5 clk = ~clk;

  gf8_mul u_gf8_mul (.clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .prod_o(prod));

  function automatic logic [2:0] ref_mul(input logic [2:0] x, input logic [2:0] y);
    logic [4:0] p = '0;
    for (int i = 0; i < 3; i++) if (y[i]) p ^= 5'(x) << i;
    for (int k = 4; k >= 3; k--) if (p[k]) p ^= 5'b01011 << (k - 3);
    return p[2:0];
  endfunction

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    nvec++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s a=%0d b=%0d got=%0d exp=%0d", req, a, b, got, exp);
    end
  endtask

  task automatic apply(input logic [2:0] x, input logic [2:0] y);
    @(negedge clk);
    a = x; b = y;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    repeat (2) @(posedge clk); #1;
    check("R6", prod, 3'd0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        apply(3'(i), 3'(j));
        check("R1", prod, ref_mul(3'(i), 3'(j)));
        if (i == 0 || j == 0) check("R2", prod, 3'd0);
        else if (prod == 3'd0) check("R7", prod, ref_mul(3'(i), 3'(j)));
      end
  endtask

  task automatic t_identity;
    for (int v = 0; v < 8; v++) begin
      apply(3'd1, 3'(v)); check("R3", prod, 3'(v));
      apply(3'(v), 3'd1); check("R3", prod, 3'(v));
    end
  endtask

  task automatic t_commute;
    logic [2:0] first;
    for (int i = 1; i < 8; i++)
      for (int j = i + 1; j < 8; j++) begin
        apply(3'(i), 3'(j)); first = prod;
        apply(3'(j), 3'(i)); check("R4", prod, first);
      end
  endtask

  task automatic t_wrap;
    apply(3'd5, 3'd7); check("R8", prod, 3'd6); // a^6*a^5=a^4
    apply(3'd7, 3'd7); check("R8", prod, 3'd3); // a^5*a^5=a^3
    apply(3'd5, 3'd5); check("R8", prod, 3'd7); // a^6*a^6=a^5
    apply(3'd5, 3'd2); check("R8", prod, 3'd1); // a^6*a^1=a^0
  endtask

  task automatic t_latency;
    apply(3'd2, 3'd2); check("R5", prod, 3'd4);
    @(negedge clk); a = 3'd3; b = 3'd3; #1;
    check("R5", prod, 3'd4);
    @(posedge clk); #1;
    check("R5", prod, 3'd5);
  endtask

  task automatic t_reset_mid;
    @(negedge clk); a = 3'd6; b = 3'd6; rst_n = 1'b0; #1;
    check("R6", prod, 3'd0);
    @(posedge clk); #1;
    check("R6", prod, 3'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", prod, ref_mul(3'd6, 3'd6));
  endtask

  initial begin
    #2ms;
    nerr++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    t_reset();
    t_sweep();
    t_identity();
    t_commute();
    t_wrap();
    t_latency();
    t_reset_mid();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule